// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary floating-point numbers (1 sign bit, 8 exponent bits, 23 fraction bits, exponent bias 127) and returns the product one clock after the operands are presented. The operands are classified first: NaN, infinity, zero and normal. Subnormal operands count as zeros that keep their sign. Special combinations go straight to a fixed result. Finite operands go through the arithmetic path. The two biased exponents are added and one bias is removed, because the raw sum holds it twice. The 24-bit significands, with their hidden leading 1 restored, are multiplied into a 48-bit product. That product is normalized by one place when it reaches 2.0 or more.

The normalized significand is rounded to nearest, with ties going to the even value. The discarded product bits supply the guard, round and sticky bits. A result below the normal range is first shifted right into subnormal form. A carry out of rounding moves into the exponent field, so a rounded result is renormalized without extra logic. Two flags report an overflow to infinity and an inexact tiny result. A host pulses `in_valid` with the operands and reads the product on the following `out_valid`.

Top module: `fpmul_sp`

## Requirements
- R1: `out_valid` is high exactly one cycle after each cycle with `in_valid` high, and low otherwise. While `in_valid` is low, `product`, `ovf_flag` and `unf_flag` keep their previous values.
- R2: Every non-NaN result has a sign bit (bit 31) equal to the XOR of the operand sign bits.
- R3: For normal operands, the result exponent field is exp_a + exp_b − 127. It is one higher when the significand product is 2.0 or more, in which case the significand is shifted right by one place.
- R4: Rounding is to nearest. An exact halfway case rounds to the value whose fraction LSB (bit 0) is 0.
- R5: If rounding carries out of the fraction, the exponent field increases by one and the fraction becomes zero. This includes a subnormal that rounds up to the smallest normal, 0x00800000.
- R6: A finite result whose exponent field would reach 255, either before or after rounding, gives a signed infinity (exponent field 255, fraction 0) with `ovf_flag` = 1.
- R7: A NaN operand (exponent field 255, fraction non-zero), or zero times infinity, gives the quiet NaN 0x7FC00000 with both flags 0.
- R8: Infinity times a non-zero value or infinity gives a signed infinity. Zero times a finite value gives a signed zero. Both flags are 0 in these cases.
- R9: A result whose adjusted exponent is below 1 before rounding is shifted right into subnormal form (exponent field 0), or to zero. `unf_flag` is 1 only if bits were lost in rounding. An exact tiny result leaves the flag at 0.
- R10: An operand with exponent field 0 and a non-zero fraction is treated as a zero of its own sign.
- R11: After reset, `out_valid`, `product`, `ovf_flag` and `unf_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands on `op_a`/`op_b` are to be multiplied |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| out_valid | output | 1 | `product` and the flags hold a fresh result |
| product | output | 32 | Rounded product |
| ovf_flag | output | 1 | Finite operands overflowed to infinity |
| unf_flag | output | 1 | Result was tiny and inexact |

## Verification
The bench builds the block with its default widths: an 8-bit exponent and a 23-bit fraction. At these widths, exact 32-bit encodings can be chosen so that the sticky bits are precisely zero at a halfway point. This makes the tie-to-even case, the odd-LSB round-up case, and the subnormal case that rounds up to 0x00800000 reachable with single directed vectors. It also allows the boundaries at exponent 254/255 and at exponent field 0 to be hit from the largest and smallest normal operands.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_NORM = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } opnd_cls_e;
endpackage

// File: rtl/fpm_decode.sv
module fpm_decode
  import fpm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] opnd,
  output opnd_cls_e             cls,
  output logic                  sgn,
  output logic [EXP_W-1:0]      expf,
  output logic [FRAC_W:0]       sig
);
  logic [FRAC_W-1:0] frac;
  logic exp_ones, exp_zero;

  assign sgn      = opnd[EXP_W+FRAC_W];
  assign expf     = opnd[EXP_W+FRAC_W-1:FRAC_W];
  assign frac     = opnd[FRAC_W-1:0];
  assign exp_ones = &expf;
  assign exp_zero = ~|expf;
  assign sig      = {1'b1, frac};

  always_comb begin
    if (exp_ones)      cls = (frac == '0) ? CLS_INF : CLS_NAN;
    else if (exp_zero) cls = CLS_ZERO;   // subnormals flushed to zero
    else               cls = CLS_NORM;
  end
endmodule

// File: rtl/fpm_round.sv
module fpm_round #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic signed [EXP_W+1:0]      exp_in,
  input  logic [2*(FRAC_W+1)-1:0]      nrm,
  output logic [EXP_W+FRAC_W-1:0]      mag,
  output logic                         ovf,
  output logic                         tiny,
  output logic                         inexact
);
  localparam int SW   = FRAC_W + 1;
  localparam int PW   = 2 * SW;
  localparam int XW   = EXP_W + 2;
  localparam int EMAX = (1 << EXP_W) - 1;

  function automatic logic rne_up(input logic lsb, input logic g, input logic r, input logic s);
    return g & (r | s | lsb);
  endfunction

  logic [XW-1:0]          sh;
  logic [PW-1:0]          shd;
  logic                   lost;
  logic [SW-1:0]          sig;
  logic                   g_bit, r_bit, s_bit, inc, big;
  logic [EXP_W-1:0]       efield;
  logic [EXP_W+FRAC_W-1:0] rounded;

  assign tiny = exp_in[XW-1] | (exp_in == '0);
  assign sh   = tiny ? ({{(XW-1){1'b0}}, 1'b1} - $unsigned(exp_in)) : '0;

  always_comb begin
    if (sh >= XW'(PW)) begin
      shd  = '0;
      lost = |nrm;
    end else begin
      shd  = nrm >> sh;
      lost = |(nrm & ~({PW{1'b1}} << sh));
    end
  end

  assign sig     = shd[PW-1 -: SW];
  assign g_bit   = shd[PW-SW-1];
  assign r_bit   = shd[PW-SW-2];
  assign s_bit   = (|shd[PW-SW-3:0]) | lost;
  assign inc     = rne_up(sig[0], g_bit, r_bit, s_bit);
  assign inexact = g_bit | r_bit | s_bit;
  assign big     = !tiny && (exp_in[XW-2:0] >= (XW-1)'(EMAX));
  assign efield  = tiny ? '0 : exp_in[EXP_W-1:0];
  // carry out of the fraction lands in the exponent field: renormalize for free
  assign rounded = {efield, sig[FRAC_W-1:0]} + (EXP_W+FRAC_W)'(inc);
  assign ovf     = big | (&rounded[EXP_W+FRAC_W-1:FRAC_W]);
  assign mag     = ovf ? {{EXP_W{1'b1}}, {FRAC_W{1'b0}}} : rounded;
endmodule

// File: rtl/fpmul_sp.sv
module fpmul_sp
  import fpm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [EXP_W+FRAC_W:0]   op_a,
  input  logic [EXP_W+FRAC_W:0]   op_b,
  output logic                    out_valid,
  output logic [EXP_W+FRAC_W:0]   product,
  output logic                    ovf_flag,
  output logic                    unf_flag
);
  localparam int W    = 1 + EXP_W + FRAC_W;
  localparam int SW   = FRAC_W + 1;
  localparam int PW   = 2 * SW;
  localparam int XW   = EXP_W + 2;
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam logic [W-2:0] INF_MAG = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  localparam logic [W-1:0] QNAN    = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  function automatic logic [PW-1:0] sig_mul(input logic [SW-1:0] x, input logic [SW-1:0] y);
    return PW'(x) * PW'(y);
  endfunction

  function automatic logic signed [XW-1:0] exp_add(input logic [EXP_W-1:0] x,
                                                   input logic [EXP_W-1:0] y,
                                                   input logic carry);
    return XW'(x) + XW'(y) - XW'(BIAS) + XW'(carry);
  endfunction

  opnd_cls_e          cls_a, cls_b;
  logic               sgn_a, sgn_b, sgn_x;
  logic [EXP_W-1:0]   exp_a, exp_b;
  logic [SW-1:0]      sig_a, sig_b;

  fpm_decode #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_dec_a (
    .opnd(op_a), .cls(cls_a), .sgn(sgn_a), .expf(exp_a), .sig(sig_a));
  fpm_decode #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_dec_b (
    .opnd(op_b), .cls(cls_b), .sgn(sgn_b), .expf(exp_b), .sig(sig_b));

  logic [PW-1:0]          sig_prod, sig_nrm;
  logic                   prod_hi;
  logic signed [XW-1:0]   exp_adj;
  logic [W-2:0]           fin_mag;
  logic                   fin_ovf, fin_tiny, fin_inexact;

  assign sgn_x    = sgn_a ^ sgn_b;
  assign sig_prod = sig_mul(sig_a, sig_b);
  assign prod_hi  = sig_prod[PW-1];
  assign sig_nrm  = prod_hi ? sig_prod : (sig_prod << 1);
  assign exp_adj  = exp_add(exp_a, exp_b, prod_hi);

  fpm_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_rnd (
    .exp_in(exp_adj), .nrm(sig_nrm), .mag(fin_mag),
    .ovf(fin_ovf), .tiny(fin_tiny), .inexact(fin_inexact));

  // named events for the checker
  logic hit_nan, hit_inf, hit_zero, fin_path;
  assign hit_nan  = (cls_a == CLS_NAN) || (cls_b == CLS_NAN) ||
                    ((cls_a == CLS_INF) && (cls_b == CLS_ZERO)) ||
                    ((cls_a == CLS_ZERO) && (cls_b == CLS_INF));
  assign hit_inf  = !hit_nan && ((cls_a == CLS_INF) || (cls_b == CLS_INF));
  assign hit_zero = !hit_nan && !hit_inf && ((cls_a == CLS_ZERO) || (cls_b == CLS_ZERO));
  assign fin_path = !hit_nan && !hit_inf && !hit_zero;

  logic [W-1:0] res_d;
  logic         ovf_d, unf_d;

  always_comb begin
    ovf_d = 1'b0;
    unf_d = 1'b0;
    if (hit_nan)       res_d = QNAN;
    else if (hit_inf)  res_d = {sgn_x, INF_MAG};
    else if (hit_zero) res_d = {sgn_x, {(W-1){1'b0}}};
    else begin
      res_d = {sgn_x, fin_mag};
      ovf_d = fin_ovf;
      unf_d = fin_tiny & fin_inexact & ~fin_ovf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      product   <= '0;
      ovf_flag  <= 1'b0;
      unf_flag  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        product  <= res_d;
        ovf_flag <= ovf_d;
        unf_flag <= unf_d;
      end
    end
  end
endmodule

// File: rtl/fpmul_sp_chk.sv
module fpmul_sp_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic [EXP_W+FRAC_W:0] op_a,
  input logic [EXP_W+FRAC_W:0] op_b,
  input logic                  out_valid,
  input logic [EXP_W+FRAC_W:0] product,
  input logic                  ovf_flag,
  input logic                  unf_flag
);
  localparam int W = 1 + EXP_W + FRAC_W;
  localparam logic [W-2:0] INF_MAG = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  localparam logic [W-1:0] QNAN    = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic out_is_nan;
  assign out_is_nan = (&product[W-2:FRAC_W]) && (product[FRAC_W-1:0] != '0);

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(product) && $stable(ovf_flag) && $stable(unf_flag)));
  a_r2_sign_xor: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_is_nan || (product[W-1] == ($past(op_a[W-1]) ^ $past(op_b[W-1])))));
  a_r7_nan_canon: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_is_nan) |-> (product == QNAN && !ovf_flag && !unf_flag));
  a_r6_ovf_inf: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ovf_flag) |-> (product[W-2:0] == INF_MAG));
  a_r9_unf_tiny: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && unf_flag) |-> (product[W-2:FRAC_W] <= 1));
  a_r9_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_flag && unf_flag));
endmodule

bind fpmul_sp fpmul_sp_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
  .out_valid(out_valid), .product(product), .ovf_flag(ovf_flag), .unf_flag(unf_flag));

// File: tb/tb_fpmul_sp.sv
`timescale 1ns/1ps
module tb_fpmul_sp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        out_valid, ovf_flag, unf_flag;
  logic [31:0] product;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  fpmul_sp dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .product(product), .ovf_flag(ovf_flag), .unf_flag(unf_flag));

  task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic run_op(input string req, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] exp_p, input logic eo, input logic eu);
    @(negedge clk);
    op_a = a; op_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    cmp({req, " valid"}, {31'd0, out_valid}, 32'd1);
    cmp({req, " product"}, product, exp_p);
    cmp({req, " flags"}, {30'd0, ovf_flag, unf_flag}, {30'd0, eo, eu});
  endtask

  task automatic t_reset;   // R11
    cmp("R11 out_valid", {31'd0, out_valid}, 32'd0);
    cmp("R11 product", product, 32'd0);
    cmp("R11 flags", {30'd0, ovf_flag, unf_flag}, 32'd0);
  endtask

  task automatic t_normal;  // R2 R3
    run_op("R3 one*one", 32'h3F800000, 32'h3F800000, 32'h3F800000, 0, 0);
    run_op("R2 R3 0.5*-0.4375", 32'h3F000000, 32'hBEE00000, 32'hBE600000, 0, 0);
    run_op("R3 two*three", 32'h40000000, 32'h40400000, 32'h40C00000, 0, 0);
    run_op("R3 1.5*1.5 shift", 32'h3FC00000, 32'h3FC00000, 32'h40100000, 0, 0);
    run_op("R2 neg*neg", 32'hC0000000, 32'hC0400000, 32'h40C00000, 0, 0);
  endtask

  task automatic t_round;   // R4 R5
    run_op("R4 tie odd up", 32'h3F800001, 32'h3FC00000, 32'h3FC00002, 0, 0);
    run_op("R4 tie even stay", 32'h3F800003, 32'h3FC00000, 32'h3FC00004, 0, 0);
    run_op("R5 sub to min normal", 32'h00FFFFFF, 32'h3F000000, 32'h00800000, 0, 1);
  endtask

  task automatic t_overflow; // R6
    run_op("R6 overflow", 32'h7F000000, 32'h40000000, 32'h7F800000, 1, 0);
    run_op("R6 neg overflow", 32'hFF000000, 32'h40000000, 32'hFF800000, 1, 0);
    run_op("R6 max*one", 32'h7F7FFFFF, 32'h3F800000, 32'h7F7FFFFF, 0, 0);
  endtask

  task automatic t_underflow; // R9
    run_op("R9 exact subnormal", 32'h00800000, 32'h3F000000, 32'h00400000, 0, 0);
    run_op("R9 flush to zero", 32'h00800000, 32'h00800000, 32'h00000000, 0, 1);
    run_op("R9 R2 neg to zero", 32'h80800000, 32'h00800000, 32'h80000000, 0, 1);
  endtask

  task automatic t_special; // R7 R8
    run_op("R7 qnan in", 32'h7FC00000, 32'h3F800000, 32'h7FC00000, 0, 0);
    run_op("R7 snan in", 32'h3F800000, 32'hFF800001, 32'h7FC00000, 0, 0);
    run_op("R7 zero*inf", 32'h00000000, 32'h7F800000, 32'h7FC00000, 0, 0);
    run_op("R8 inf*-2", 32'h7F800000, 32'hC0000000, 32'hFF800000, 0, 0);
    run_op("R8 inf*inf", 32'hFF800000, 32'h7F800000, 32'hFF800000, 0, 0);
    run_op("R8 -0*5", 32'h80000000, 32'h40A00000, 32'h80000000, 0, 0);
  endtask

  task automatic t_subnormal_in; // R10
    run_op("R10 sub*two", 32'h00000001, 32'h40000000, 32'h00000000, 0, 0);
    run_op("R10 negsub*two", 32'h807FFFFF, 32'h40000000, 32'h80000000, 0, 0);
    run_op("R10 sub*inf", 32'h00000001, 32'h7F800000, 32'h7FC00000, 0, 0);
  endtask

  task automatic t_hold;    // R1
    run_op("R1 setup", 32'h7F000000, 32'h40000000, 32'h7F800000, 1, 0);
    @(negedge clk);
    op_a = 32'h3F800000; op_b = 32'h3F800000;   // in_valid stays low
    @(negedge clk);
    @(negedge clk);
    cmp("R1 idle valid", {31'd0, out_valid}, 32'd0);
    cmp("R1 idle product", product, 32'h7F800000);
    cmp("R1 idle flags", {30'd0, ovf_flag, unf_flag}, 32'd2);
  endtask

  initial begin
    #3;
    t_reset;
    @(negedge clk);
    rst_n = 1'b1;
    t_normal;
    t_round;
    t_overflow;
    t_underflow;
    t_special;
    t_subnormal_in;
    t_hold;
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule